// File: doc/BRIEF.md
# Strap-Selected Host Bus Front End

This block sits between a microprocessor and the core of a display controller. The host writes bytes over an 8-bit bus. Each byte reaches the core as a single-cycle write-valid pulse. The pulse carries the byte and a flag that says whether the byte is display data or a command. Two static straps choose the host protocol:

- 8080-style parallel signalling, with separate read and write strobes.
- 6800-style parallel signalling, with an enable strobe and a direction input.
- A two-wire serial input that reuses the top two data pins.

The device responds only while both chip-select inputs are at their active levels. For parallel reads, the block drives the read-back byte supplied by the core onto the bus. It does so through a per-bit output enable, so the pad ring can build the tri-state buffer.

The control pins, data pins and chip selects are brought into the core clock domain through a shared multi-stage synchroniser. Edges are found by comparing the synchronised sample with the one from the previous cycle. The read drive path stays combinational from the pins, so the bus turns around as fast as the host strobes it. An active-low reset clears all state and keeps the bus undriven while it is held.

Top module: `hbf_top`

## Requirements
- R1: A write is accepted only when the active-low select `cs_lo_n` is 0 and the active-high select `cs_hi` is 1 at the same time. A strobe sequence with either select inactive produces no `wr_valid` pulse.
- R2: While the device is not selected, `bus_oe` is all zeros.
- R3: 8080 mode (`m68_sel`=0, `ser_sel`=0): while selected and `strb_a` (read, active low) is 0, `bus_oe` is all ones and `bus_out` equals `rd_data`.
- R4: 8080 mode: a rising edge on `strb_b` (write, active low) while selected captures `bus_in`. `wr_valid` rises at the third rising clock edge after the pin edge.
- R5: 6800 mode (`m68_sel`=1, `ser_sel`=0): while selected with `strb_a` (enable) 1 and `strb_b` (direction, 1 = read) 1, `bus_oe` is all ones and `bus_out` equals `rd_data`.
- R6: 6800 mode: a falling edge of `strb_a` while `strb_b` is 0 and the device is selected captures `bus_in`, with the same latency as R4. While `strb_b` is 0, the bus is never driven.
- R7: `wr_is_data` equals the level of `dsel` at the capturing edge: 1 for display data, 0 for a command byte.
- R8: Serial mode (`ser_sel`=1): `bus_in[7]` is the data bit and `bus_in[6]` the clock. Bits are shifted MSB first on rising clock edges. The eighth edge produces a pulse at the third clock edge after it, with `dsel` taken at that eighth edge.
- R9: In serial mode `bus_oe` is all zeros, and toggling the parallel strobes produces no write.
- R10: In serial mode the bit counter clears whenever the device is deselected, so a partial byte is discarded.
- R11: While `rst_n` is 0, `bus_oe` is all zeros and `wr_valid` is 0 whatever the pins do.
- R12: Each accepted byte gives exactly one `wr_valid` pulse, one cycle wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_lo_n | input | 1 | Chip select, active low |
| cs_hi | input | 1 | Chip select, active high |
| dsel | input | 1 | 1 = display data, 0 = command |
| strb_a | input | 1 | 8080: read strobe (active low); 6800: enable (active high) |
| strb_b | input | 1 | 8080: write strobe (active low); 6800: direction (1 read, 0 write) |
| m68_sel | input | 1 | Strap: 1 selects 6800 signalling, 0 selects 8080 |
| ser_sel | input | 1 | Strap: 1 selects the serial input |
| bus_in | input | 8 | Data pins as seen from the pad |
| bus_out | output | 8 | Read-back byte to the pad |
| bus_oe | output | 8 | Per-bit pad output enable |
| rd_data | input | 8 | Read-back byte supplied by the core |
| wr_valid | output | 1 | One-cycle pulse per accepted byte |
| wr_byte | output | 8 | Accepted byte |
| wr_is_data | output | 1 | Data/command flag of the accepted byte |

## Verification
Written bytes pass through two synchroniser stages and one output register. So the pulse for any capturing pin edge is due at exactly the third rising clock edge after that edge. The bench drives each final edge on a falling clock edge. It then samples 1 ns after each of the next four rising edges and requires the pulse to be absent, absent, present with the expected byte and flag, then absent again. It also recounts pulses a few cycles later to catch repeats. Output enable and read-back data are combinational from the pins, so they are checked 1 ns after the pins change, within the same cycle.

// File: rtl/hbf_pkg.sv
package hbf_pkg;

    typedef enum logic [1:0] {
        HBF_I80 = 2'd0,
        HBF_M68 = 2'd1,
        HBF_SER = 2'd2
    } hbf_mode_e;

    // Strap decoding: serial overrides both parallel flavours.
    function automatic hbf_mode_e hbf_mode(input logic ser, input logic m68);
        if (ser)      return HBF_SER;
        else if (m68) return HBF_M68;
        else          return HBF_I80;
    endfunction

endpackage

// File: rtl/hbf_sync.sv
module hbf_sync #(
    parameter int             W       = 8,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[g] <= RST_VAL;
            else        stg_q[g] <= stg_d[g];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/hbf_par_decode.sv
module hbf_par_decode
    import hbf_pkg::*;
(
    input  hbf_mode_e mode_i,
    // synchronised view: previous and current samples
    input  logic      prev_sel_i,
    input  logic      prev_a_i,
    input  logic      prev_b_i,
    input  logic      cur_a_i,
    input  logic      cur_b_i,
    // raw pin view for the read drive
    input  logic      raw_sel_i,
    input  logic      raw_a_i,
    input  logic      raw_b_i,
    output logic      hit_o,
    output logic      drive_o
);
    always_comb begin
        hit_o   = 1'b0;
        drive_o = 1'b0;
        unique case (mode_i)
            HBF_I80: begin
                // write strobe released (low to high) while selected
                hit_o   = prev_sel_i && !prev_b_i && cur_b_i;
                drive_o = raw_sel_i && !raw_a_i;
            end
            HBF_M68: begin
                // enable falls while direction says write
                hit_o   = prev_sel_i && prev_a_i && !cur_a_i && !prev_b_i;
                drive_o = raw_sel_i && raw_a_i && raw_b_i;
            end
            default: begin
                hit_o   = 1'b0;
                drive_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/hbf_ser_shift.sv
module hbf_ser_shift #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          cur_sel_i,
    input  logic          prev_sel_i,
    input  logic          cur_sck_i,
    input  logic          prev_sck_i,
    input  logic          cur_sdi_i,
    output logic          done_o,
    output logic [DW-1:0] byte_o
);
    localparam int CW = (DW > 2) ? $clog2(DW) : 1;
    localparam logic [CW-1:0] LAST = CW'(DW-1);

    typedef struct packed {
        logic [DW-1:0] shreg;
        logic [CW-1:0] cnt;
    } ser_t;

    ser_t st_d, st_q;
    logic rise;

    assign rise = en_i && cur_sel_i && prev_sel_i && cur_sck_i && !prev_sck_i;

    always_comb begin
        st_d   = st_q;
        done_o = 1'b0;
        byte_o = {st_q.shreg[DW-2:0], cur_sdi_i};
        if (!en_i || !cur_sel_i) begin
            st_d.cnt = '0;
        end else if (rise) begin
            st_d.shreg = {st_q.shreg[DW-2:0], cur_sdi_i};
            if (st_q.cnt == LAST) begin
                done_o   = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/hbf_top.sv
module hbf_top
    import hbf_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2,
    parameter bit HAS_SERIAL  = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_lo_n,
    input  logic          cs_hi,
    input  logic          dsel,
    input  logic          strb_a,
    input  logic          strb_b,
    input  logic          m68_sel,
    input  logic          ser_sel,
    input  logic [DW-1:0] bus_in,
    output logic [DW-1:0] bus_out,
    output logic [DW-1:0] bus_oe,
    input  logic [DW-1:0] rd_data,
    output logic          wr_valid,
    output logic [DW-1:0] wr_byte,
    output logic          wr_is_data
);
    localparam int SDI_BIT = DW - 1;
    localparam int SCK_BIT = DW - 2;
    localparam int CTL_W   = 5;
    localparam int SW      = CTL_W + DW;
    localparam int P_CSL   = SW - 1;
    localparam int P_CSH   = SW - 2;
    localparam int P_DSEL  = SW - 3;
    localparam int P_STA   = SW - 4;
    localparam int P_STB   = SW - 5;
    localparam logic [SW-1:0] SYNC_IDLE = {1'b1, {(SW-1){1'b0}}};

    typedef struct packed {
        logic csl;
        logic csh;
        logic sta;
        logic stb;
        logic sck;
    } hist_t;

    typedef struct packed {
        hist_t         hist;
        logic          vld;
        logic [DW-1:0] byt;
        logic          dc;
    } front_t;

    localparam front_t FRONT_RST = '{hist: '{csl: 1'b1, default: 1'b0},
                                     vld: 1'b0, byt: '0, dc: 1'b0};

    hbf_mode_e     mode;
    logic [SW-1:0] raw_vec, cur_vec;
    logic          cur_sel, prev_sel, raw_sel;
    logic          par_hit, par_drive;
    logic          ser_done;
    logic [DW-1:0] ser_byte;
    front_t        st_d, st_q;

    assign mode    = hbf_mode(ser_sel, m68_sel);
    assign raw_vec = {cs_lo_n, cs_hi, dsel, strb_a, strb_b, bus_in};

    hbf_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_IDLE)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_vec),
        .q_o   (cur_vec)
    );

    assign raw_sel  = !cs_lo_n && cs_hi;
    assign cur_sel  = !cur_vec[P_CSL] && cur_vec[P_CSH];
    assign prev_sel = !st_q.hist.csl && st_q.hist.csh;

    hbf_par_decode u_par (
        .mode_i     (mode),
        .prev_sel_i (prev_sel),
        .prev_a_i   (st_q.hist.sta),
        .prev_b_i   (st_q.hist.stb),
        .cur_a_i    (cur_vec[P_STA]),
        .cur_b_i    (cur_vec[P_STB]),
        .raw_sel_i  (raw_sel),
        .raw_a_i    (strb_a),
        .raw_b_i    (strb_b),
        .hit_o      (par_hit),
        .drive_o    (par_drive)
    );

    if (HAS_SERIAL) begin : g_ser
        hbf_ser_shift #(.DW(DW)) u_ser (
            .clk        (clk),
            .rst_n      (rst_n),
            .en_i       (mode == HBF_SER),
            .cur_sel_i  (cur_sel),
            .prev_sel_i (prev_sel),
            .cur_sck_i  (cur_vec[SCK_BIT]),
            .prev_sck_i (st_q.hist.sck),
            .cur_sdi_i  (cur_vec[SDI_BIT]),
            .done_o     (ser_done),
            .byte_o     (ser_byte)
        );
    end else begin : g_noser
        assign ser_done = 1'b0;
        assign ser_byte = '0;
    end

    always_comb begin
        st_d          = st_q;
        st_d.hist.csl = cur_vec[P_CSL];
        st_d.hist.csh = cur_vec[P_CSH];
        st_d.hist.sta = cur_vec[P_STA];
        st_d.hist.stb = cur_vec[P_STB];
        st_d.hist.sck = cur_vec[SCK_BIT];
        st_d.vld      = 1'b0;
        if (mode == HBF_SER) begin
            if (ser_done) begin
                st_d.vld = 1'b1;
                st_d.byt = ser_byte;
                st_d.dc  = cur_vec[P_DSEL];
            end
        end else if (par_hit) begin
            st_d.vld = 1'b1;
            st_d.byt = cur_vec[DW-1:0];
            st_d.dc  = cur_vec[P_DSEL];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FRONT_RST;
        else        st_q <= st_d;
    end

    assign bus_oe     = {DW{rst_n && par_drive}};
    assign bus_out    = rd_data;
    assign wr_valid   = st_q.vld;
    assign wr_byte    = st_q.byt;
    assign wr_is_data = st_q.dc;
endmodule

// File: rtl/hbf_checker.sv
module hbf_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_lo_n,
    input logic          cs_hi,
    input logic          strb_a,
    input logic          strb_b,
    input logic          m68_sel,
    input logic          ser_sel,
    input logic [DW-1:0] bus_oe,
    input logic [DW-1:0] bus_out,
    input logic [DW-1:0] rd_data,
    input logic          wr_valid
);
    logic sel;
    assign sel = !cs_lo_n && cs_hi;

    AST_OE_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> bus_oe == '0); // R2

    AST_I80_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !ser_sel && !m68_sel && !strb_a) |-> (bus_oe == '1 && bus_out == rd_data)); // R3

    AST_M68_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !ser_sel && m68_sel && strb_a && strb_b) |-> (bus_oe == '1 && bus_out == rd_data)); // R5

    AST_M68_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (m68_sel && !strb_b) |-> bus_oe == '0); // R6

    AST_SERIAL_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ser_sel |-> bus_oe == '0); // R9

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> bus_oe == '0); // R11

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid); // R12
endmodule

bind hbf_top hbf_checker #(.DW(DW)) u_hbf_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_lo_n  (cs_lo_n),
    .cs_hi    (cs_hi),
    .strb_a   (strb_a),
    .strb_b   (strb_b),
    .m68_sel  (m68_sel),
    .ser_sel  (ser_sel),
    .bus_oe   (bus_oe),
    .bus_out  (bus_out),
    .rd_data  (rd_data),
    .wr_valid (wr_valid)
);

// File: tb/tb_hbf_top.sv
`timescale 1ns/1ps
module tb_hbf_top;
    localparam int DW = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n, cs_lo_n, cs_hi, dsel, strb_a, strb_b, m68_sel, ser_sel;
    logic [DW-1:0] bus_in, bus_out, bus_oe, rd_data, wr_byte;
    logic          wr_valid, wr_is_data;

    hbf_top dut (
        .clk(clk), .rst_n(rst_n), .cs_lo_n(cs_lo_n), .cs_hi(cs_hi), .dsel(dsel),
        .strb_a(strb_a), .strb_b(strb_b), .m68_sel(m68_sel), .ser_sel(ser_sel),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .rd_data(rd_data),
        .wr_valid(wr_valid), .wr_byte(wr_byte), .wr_is_data(wr_is_data)
    );

    int checks = 0;
    int errors = 0;
    int npulse = 0;
    bit done   = 1'b0;

    always @(negedge clk) if (rst_n && wr_valid) npulse++;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [DW-1:0] exp_oe(input logic rst, input logic csl, input logic csh,
                                             input logic m68, input logic ser,
                                             input logic a, input logic b);
        logic drv;
        drv = rst && !csl && csh && !ser && (m68 ? (a && b) : !a);
        return drv ? '1 : '0;
    endfunction

    task automatic idle_pins();
        cs_lo_n = 1'b1; cs_hi = 1'b0;
        strb_a  = m68_sel ? 1'b0 : 1'b1;
        strb_b  = 1'b1;
    endtask

    task automatic set_mode(input int mode);
        cs_lo_n = 1'b1; cs_hi = 1'b0; bus_in = '0;
        m68_sel = (mode == 1); ser_sel = (mode == 2);
        idle_pins();
        cyc(4);
    endtask

    // called on a falling clock edge right after the capturing pin edge
    task automatic expect_pulse(input string req, input logic [7:0] b, input logic dc);
        int base = npulse;
        @(posedge clk); #1 chk(req, "no pulse at edge 1", wr_valid, 0);
        @(posedge clk); #1 chk(req, "no pulse at edge 2", wr_valid, 0);
        @(posedge clk); #1 chk(req, "pulse at edge 3", wr_valid, 1);
        chk(req, "byte", wr_byte, b);
        chk("R7", "data/command flag", wr_is_data, dc);
        @(posedge clk); #1 chk("R12", "pulse width", wr_valid, 0);
        cyc(4);
        chk("R12", "pulse count", npulse - base, 1);
    endtask

    task automatic expect_none(input string req);
        int base = npulse;
        cyc(6);
        chk(req, "no write pulse", npulse - base, 0);
    endtask

    task automatic do_write(input int mode, input logic [7:0] b, input logic dc,
                            input logic csl, input logic csh, input bit flip_dc,
                            input string req);
        bit sel = !csl && csh;
        cs_lo_n = csl; cs_hi = csh; dsel = flip_dc ? ~dc : dc;
        if (mode == 0) begin
            bus_in = b; cyc(3); strb_b = 1'b0; cyc(3); strb_b = 1'b1;
        end else if (mode == 1) begin
            bus_in = b; strb_b = 1'b0; cyc(3); strb_a = 1'b1; cyc(3); strb_a = 1'b0;
        end else begin
            bus_in = '0; cyc(3);
            for (int i = 0; i < 8; i++) begin
                bus_in[7] = b[7-i]; bus_in[6] = 1'b0;
                if (i == 7) dsel = dc;
                cyc(2);
                bus_in[6] = 1'b1;
                if (i < 7) cyc(2);
            end
        end
        if (sel) expect_pulse(req, b, dc);
        else     expect_none(req);
        strb_b = 1'b1; bus_in[6] = 1'b0;
        cyc(1); idle_pins(); cyc(3);
    endtask

    task automatic rd_check(input string req, input logic csl, input logic csh,
                            input logic a, input logic b);
        logic [DW-1:0] e;
        rd_data = DW'($urandom);
        cs_lo_n = csl; cs_hi = csh; strb_a = a; strb_b = b;
        #1;
        e = exp_oe(rst_n, csl, csh, m68_sel, ser_sel, a, b);
        chk(req, "bus_oe", bus_oe, e);
        if (e != '0) chk(req, "bus_out", bus_out, rd_data);
        cyc(1); idle_pins(); cyc(1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; m68_sel = 1'b0; ser_sel = 1'b0; dsel = 1'b0;
        bus_in = '0; rd_data = 8'hA5;
        idle_pins();
        cyc(2);
        // R11: selected read and a write strobe during reset
        cs_lo_n = 1'b0; cs_hi = 1'b1; strb_a = 1'b0; strb_b = 1'b0;
        #1 chk("R11", "oe in reset", bus_oe, 0);
        cyc(2); strb_b = 1'b1; cyc(2);
        chk("R11", "wr_valid in reset", wr_valid, 0);
        idle_pins(); cyc(1);
        rst_n = 1'b1; cyc(3);
        chk("R11", "wr_valid after reset", wr_valid, 0);
        chk("R2", "oe deselected", bus_oe, 0);

        // directed 8080
        set_mode(0);
        do_write(0, 8'h3C, 1'b1, 1'b0, 1'b1, 0, "R4");
        do_write(0, 8'hC3, 1'b0, 1'b0, 1'b1, 0, "R4");
        do_write(0, 8'h11, 1'b1, 1'b0, 1'b0, 0, "R1");
        do_write(0, 8'h22, 1'b1, 1'b1, 1'b1, 0, "R1");
        rd_check("R3", 1'b0, 1'b1, 1'b0, 1'b1);
        rd_check("R2", 1'b1, 1'b1, 1'b0, 1'b1);
        rd_check("R2", 1'b0, 1'b0, 1'b0, 1'b1);

        // directed 6800
        set_mode(1);
        do_write(1, 8'h96, 1'b0, 1'b0, 1'b1, 0, "R6");
        do_write(1, 8'h69, 1'b1, 1'b0, 1'b1, 0, "R6");
        do_write(1, 8'h44, 1'b0, 1'b1, 1'b0, 0, "R1");
        rd_check("R5", 1'b0, 1'b1, 1'b1, 1'b1);
        rd_check("R6", 1'b0, 1'b1, 1'b1, 1'b0);
        // enable pulse with direction = read: no write
        cs_lo_n = 1'b0; cs_hi = 1'b1; strb_b = 1'b1; cyc(3);
        strb_a = 1'b1; cyc(3); strb_a = 1'b0;
        expect_none("R6");
        idle_pins(); cyc(2);

        // directed serial
        set_mode(2);
        do_write(2, 8'hB4, 1'b1, 1'b0, 1'b1, 0, "R8");
        do_write(2, 8'h81, 1'b0, 1'b0, 1'b1, 1, "R8");
        do_write(2, 8'h7E, 1'b1, 1'b1, 1'b1, 0, "R1");
        rd_check("R9", 1'b0, 1'b1, 1'b0, 1'b1);
        // parallel strobes in serial mode are ignored
        cs_lo_n = 1'b0; cs_hi = 1'b1; cyc(3);
        strb_b = 1'b0; cyc(3); strb_b = 1'b1; strb_a = 1'b0; cyc(3); strb_a = 1'b1;
        expect_none("R9");
        idle_pins(); cyc(2);
        // R10: partial byte then deselect, then a full byte
        cs_lo_n = 1'b0; cs_hi = 1'b1; dsel = 1'b0; cyc(3);
        for (int i = 0; i < 3; i++) begin
            bus_in[7] = 1'b1; bus_in[6] = 1'b0; cyc(2); bus_in[6] = 1'b1; cyc(2);
        end
        bus_in[6] = 1'b0; cyc(1);
        cs_lo_n = 1'b1; cyc(5);
        chk("R10", "no pulse from partial byte", wr_valid, 0);
        do_write(2, 8'h5A, 1'b0, 1'b0, 1'b1, 0, "R10");

        // constrained random mix
        for (int n = 0; n < 40; n++) begin
            int          mode = int'($urandom_range(0, 2));
            logic [7:0]  b    = 8'($urandom);
            logic        dc   = 1'($urandom);
            bit          good = ($urandom_range(0, 3) != 0);
            logic        csl  = good ? 1'b0 : 1'($urandom);
            logic        csh  = good ? 1'b1 : ~csl ? 1'b0 : 1'($urandom);
            set_mode(mode);
            do_write(mode, b, dc, csl, csh, 0,
                     mode == 0 ? "R4" : (mode == 1 ? "R6" : "R8"));
            rd_check(mode == 0 ? "R3" : (mode == 1 ? "R5" : "R9"),
                     1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule